// File: doc/BRIEF.md
# Pipeline Forwarding and Load-Use Interlock

This block resolves read-after-write hazards for an in-order pipeline with five stages: fetch, decode, execute, memory and write-back. Registers are read in decode and written in write-back, and every instruction passes through all five stages. Because of that ordering, write-after-read and write-after-write conflicts cannot arise, so only true dependences need handling. The block looks at the register numbers and control bits held in the four inter-stage registers. From these it produces operand source selects for the execute stage, a store-data source select for the memory stage, and decode-stage register-file bypass flags. It also produces a stall, which holds the program counter and the fetch/decode register and turns the decode/execute register into a bubble.

A result that is still in flight in the memory stage or the write-back stage is steered to the ALU operand that names it. When both stages hold a matching result, the younger one in the memory stage wins. A load cannot hand its data to the instruction directly behind it in execute, so a single bubble is inserted in that case. The one exception is a store that needs the loaded register only as its data. That store runs without a stall, and it picks up the loaded value from write-back once it reaches the memory stage.

A two-state interlock machine tracks the bubble. In state FLOW the stall is computed from the hazard check. A detected load-use hazard takes the transition FLOW->BUBBLE. In state BUBBLE the execute stage holds the inserted no-op: its operand selects are forced to the register file and no stall is raised. The transition BUBBLE->FLOW is then taken unconditionally, or BUBBLE->FLOW is not taken only if reset is applied, which returns the machine to FLOW.

Top module: `hz_unit`

## Requirements
- R1: Reset puts the interlock machine in FLOW; with all inputs idle, every select is 00, and `ex_bubble`, `stall`, `st_from_wb`, `id_byp_a` and `id_byp_b` are all 0.
- R2: `sel_a` (or `sel_b`) is 01 when the memory stage writes a nonzero register equal to `ex_rs1` (or `ex_rs2`).
- R3: `sel_a` (or `sel_b`) is 10 when only the write-back stage writes a nonzero register equal to the execute source.
- R4: When both the memory and write-back stages write the execute source register, the select is 01.
- R5: Register 0, or a stage whose write enable is low, never causes a forward, a bypass or a stall.
- R6: `stall` is 1 when execute holds a load (`ex_is_load` and `ex_wen`) whose nonzero `ex_rd` equals a decode source whose use flag is set; an unused source never stalls.
- R7: A decode store whose only match with the load is its data register (`id_rs2`) does not stall; a match on its base register (`id_rs1`) does.
- R8: When execute holds a store and the memory stage holds a load, `sel_b` never takes 01: it is 10 if write-back matches `ex_rs2`, else 00.
- R9: `st_from_wb` is 1 when the memory stage holds a store whose `mem_rs2` equals the nonzero register written by write-back.
- R10: In the cycle after a stall, `ex_bubble` is 1, both `sel_a` and `sel_b` are 00, and `stall` is 0 whatever the inputs; the cycle after that, `ex_bubble` is 0.
- R11: `id_byp_a` (or `id_byp_b`) is 1 when write-back writes a nonzero register equal to `id_rs1` (or `id_rs2`).
- R12: `stall` is never 1 on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_rs1 | input | AW | Decode first source register |
| id_rs2 | input | AW | Decode second source register |
| id_use_rs1 | input | 1 | Decode reads its first source |
| id_use_rs2 | input | 1 | Decode reads its second source |
| id_is_store | input | 1 | Decode holds a store (second source is store data) |
| ex_rs1 | input | AW | Execute first source register |
| ex_rs2 | input | AW | Execute second source register |
| ex_rd | input | AW | Execute destination register |
| ex_wen | input | 1 | Execute writes a register |
| ex_is_load | input | 1 | Execute holds a load |
| ex_is_store | input | 1 | Execute holds a store |
| mem_rd | input | AW | Memory-stage destination register |
| mem_wen | input | 1 | Memory stage writes a register |
| mem_is_load | input | 1 | Memory stage holds a load |
| mem_is_store | input | 1 | Memory stage holds a store |
| mem_rs2 | input | AW | Store-data register of the memory-stage store |
| wb_rd | input | AW | Write-back destination register |
| wb_wen | input | 1 | Write-back writes a register |
| sel_a | output | 2 | First ALU operand source: 00 register file, 01 memory stage, 10 write-back |
| sel_b | output | 2 | Second ALU operand source, same encoding |
| st_from_wb | output | 1 | Store data in memory stage taken from write-back |
| id_byp_a | output | 1 | Decode first source bypassed from write-back |
| id_byp_b | output | 1 | Decode second source bypassed from write-back |
| stall | output | 1 | Hold fetch and decode, insert a bubble into execute |
| ex_bubble | output | 1 | Execute stage holds an inserted bubble |

## Verification
A corrupted interlock state shows up at the ports in the very next cycle. If the machine stays in BUBBLE, the operand selects stick at 00 while a matching result waits in the memory stage. If it never enters BUBBLE, `ex_bubble` stays low after a stall. Wrong priority or a missing register-0 check changes `sel_a`, `sel_b` or `stall` combinationally, in the same cycle as the offending stage contents. The bench therefore samples each select within the cycle it drives, and steps the clock only around the stall and bubble sequence.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        SRC_RF    = 2'b00,
        SRC_EXMEM = 2'b01,
        SRC_MEMWB = 2'b10
    } fwd_src_e;

    typedef enum logic {
        ST_FLOW   = 1'b0,
        ST_BUBBLE = 1'b1
    } ilk_state_e;

    localparam int unsigned NUM_EX_OPS = 2;

endpackage

// File: rtl/hz_src_sel.sv
module hz_src_sel
    import hz_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] rs,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic          mem_block,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    input  logic          squash,
    output fwd_src_e      sel
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = mem_wen && (mem_rd != ZERO_REG) && (mem_rd == rs) && !mem_block;
        wb_hit  = wb_wen && (wb_rd != ZERO_REG) && (wb_rd == rs);
        if (squash)
            sel = SRC_RF;
        else if (mem_hit)
            sel = SRC_EXMEM;
        else if (wb_hit)
            sel = SRC_MEMWB;
        else
            sel = SRC_RF;
    end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_use_rs1,
    input  logic          id_use_rs2,
    input  logic          id_is_store,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_is_load,
    output logic          hazard
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic load_live;
    logic hit_base;
    logic hit_data;

    always_comb begin
        load_live = ex_is_load && ex_wen && (ex_rd != ZERO_REG);
        hit_base  = id_use_rs1 && (id_rs1 == ex_rd);
        // store data is picked up later from write-back, so it never stalls
        hit_data  = id_use_rs2 && (id_rs2 == ex_rd) && !id_is_store;
        hazard    = load_live && (hit_base || hit_data);
    end
endmodule

// File: rtl/hz_ilk_fsm.sv
module hz_ilk_fsm
    import hz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    output logic stall,
    output logic bubble
);
    ilk_state_e state_q;
    ilk_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_FLOW;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        stall   = 1'b0;
        bubble  = 1'b0;
        unique case (state_q)
            ST_FLOW: begin
                stall = hazard;
                if (hazard)
                    state_d = ST_BUBBLE;
            end
            ST_BUBBLE: begin
                bubble  = 1'b1;
                state_d = ST_FLOW;
            end
            default: state_d = ST_FLOW;
        endcase
    end
endmodule

// File: rtl/hz_unit.sv
module hz_unit
    import hz_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_use_rs1,
    input  logic          id_use_rs2,
    input  logic          id_is_store,
    input  logic [AW-1:0] ex_rs1,
    input  logic [AW-1:0] ex_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_is_load,
    input  logic          ex_is_store,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic          mem_is_load,
    input  logic          mem_is_store,
    input  logic [AW-1:0] mem_rs2,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b,
    output logic          st_from_wb,
    output logic          id_byp_a,
    output logic          id_byp_b,
    output logic          stall,
    output logic          ex_bubble
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic [NUM_EX_OPS-1:0][AW-1:0] ex_src;
    logic [NUM_EX_OPS-1:0]         mem_block;
    fwd_src_e                      op_sel [NUM_EX_OPS];
    logic                          hazard;
    logic                          wb_live;

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    // the load value is not ready while the store sits in execute
    assign mem_block[0] = 1'b0;
    assign mem_block[1] = ex_is_store && mem_is_load;

    for (genvar k = 0; k < NUM_EX_OPS; k++) begin : g_op
        hz_src_sel #(.AW(AW)) u_sel (
            .rs        (ex_src[k]),
            .mem_rd    (mem_rd),
            .mem_wen   (mem_wen),
            .mem_block (mem_block[k]),
            .wb_rd     (wb_rd),
            .wb_wen    (wb_wen),
            .squash    (ex_bubble),
            .sel       (op_sel[k])
        );
    end

    assign sel_a = op_sel[0];
    assign sel_b = op_sel[1];

    hz_load_use #(.AW(AW)) u_lu (
        .id_rs1      (id_rs1),
        .id_rs2      (id_rs2),
        .id_use_rs1  (id_use_rs1),
        .id_use_rs2  (id_use_rs2),
        .id_is_store (id_is_store),
        .ex_rd       (ex_rd),
        .ex_wen      (ex_wen),
        .ex_is_load  (ex_is_load),
        .hazard      (hazard)
    );

    hz_ilk_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hazard (hazard),
        .stall  (stall),
        .bubble (ex_bubble)
    );

    always_comb begin
        wb_live    = wb_wen && (wb_rd != ZERO_REG);
        st_from_wb = wb_live && mem_is_store && (mem_rs2 == wb_rd);
        id_byp_a   = wb_live && (id_rs1 == wb_rd);
        id_byp_b   = wb_live && (id_rs2 == wb_rd);
    end
endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk #(
    parameter int unsigned AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] ex_rs1,
    input logic [AW-1:0] ex_rs2,
    input logic          ex_is_load,
    input logic          ex_wen,
    input logic          ex_is_store,
    input logic [AW-1:0] mem_rd,
    input logic          mem_wen,
    input logic          mem_is_load,
    input logic          mem_is_store,
    input logic [AW-1:0] wb_rd,
    input logic          wb_wen,
    input logic [1:0]    sel_a,
    input logic [1:0]    sel_b,
    input logic          st_from_wb,
    input logic          stall,
    input logic          ex_bubble
);
    // R12: never two stalls back to back
    a_r12_single_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R10: a stall is followed by a bubble in execute
    a_r10_bubble_follows: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ex_bubble);

    // R10: a bubble takes no forwarded operand
    a_r10_bubble_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        ex_bubble |-> (sel_a == 2'b00 && sel_b == 2'b00));

    // R4: write-back chosen only when the memory stage does not match
    a_r4_mem_first: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == 2'b10) |-> !(mem_wen && mem_rd != '0 && mem_rd == ex_rs1));

    // R5: register 0 is never forwarded
    a_r5_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs1 == '0) |-> (sel_a == 2'b00));

    // R6: a stall needs a writing load in execute
    a_r6_stall_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ex_is_load && ex_wen));

    // R8: store data never taken from an in-flight load
    a_r8_no_early_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_store && mem_is_load) |-> (sel_b != 2'b01));

    // R9: store-data forward only for a store in memory stage
    a_r9_store_only: assert property (@(posedge clk) disable iff (!rst_n)
        st_from_wb |-> (mem_is_store && wb_wen && wb_rd != '0));

    // R2: select code 01 only with a writing memory stage
    a_r2_mem_src_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b == 2'b01) |-> (mem_wen && mem_rd == ex_rs2));
endmodule

bind hz_unit hz_unit_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ex_rs1       (ex_rs1),
    .ex_rs2       (ex_rs2),
    .ex_is_load   (ex_is_load),
    .ex_wen       (ex_wen),
    .ex_is_store  (ex_is_store),
    .mem_rd       (mem_rd),
    .mem_wen      (mem_wen),
    .mem_is_load  (mem_is_load),
    .mem_is_store (mem_is_store),
    .wb_rd        (wb_rd),
    .wb_wen       (wb_wen),
    .sel_a        (sel_a),
    .sel_b        (sel_b),
    .st_from_wb   (st_from_wb),
    .stall        (stall),
    .ex_bubble    (ex_bubble)
);

// File: tb/hz_unit_test.sv
module hz_unit_test;
    localparam int unsigned AW = 5;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd;
    logic id_use_rs1, id_use_rs2, id_is_store;
    logic ex_wen, ex_is_load, ex_is_store;
    logic mem_wen, mem_is_load, mem_is_store, wb_wen;
    logic [1:0] sel_a, sel_b;
    logic st_from_wb, id_byp_a, id_byp_b, stall, ex_bubble;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hz_unit #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1),
        .id_use_rs2(id_use_rs2), .id_is_store(id_is_store),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_wen(ex_wen),
        .ex_is_load(ex_is_load), .ex_is_store(ex_is_store),
        .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_is_load(mem_is_load),
        .mem_is_store(mem_is_store), .mem_rs2(mem_rs2),
        .wb_rd(wb_rd), .wb_wen(wb_wen),
        .sel_a(sel_a), .sel_b(sel_b), .st_from_wb(st_from_wb),
        .id_byp_a(id_byp_a), .id_byp_b(id_byp_b),
        .stall(stall), .ex_bubble(ex_bubble)
    );

    task automatic chk(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic set_idle();
        id_rs1 = '0; id_rs2 = '0; id_use_rs1 = 0; id_use_rs2 = 0; id_is_store = 0;
        ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0; ex_wen = 0; ex_is_load = 0; ex_is_store = 0;
        mem_rd = '0; mem_wen = 0; mem_is_load = 0; mem_is_store = 0; mem_rs2 = '0;
        wb_rd = '0; wb_wen = 0;
    endtask

    task automatic next_cycle();
        @(negedge clk);
    endtask

    task automatic settle_idle();
        set_idle();
        next_cycle();
        next_cycle();
    endtask

    task automatic t_reset();
        set_idle();
        rst_n = 1'b0;
        next_cycle();
        #1;
        chk("R1 sel_a", sel_a, 0);
        chk("R1 sel_b", sel_b, 0);
        chk("R1 stall", stall, 0);
        chk("R1 bubble", ex_bubble, 0);
        chk("R1 st_from_wb", st_from_wb, 0);
        chk("R1 byp", {id_byp_a, id_byp_b}, 0);
        rst_n = 1'b1;
        next_cycle();
    endtask

    task automatic t_alu_fwd();
        set_idle();
        ex_rs1 = 5'd3; mem_rd = 5'd3; mem_wen = 1;
        ex_rs2 = 5'd4; wb_rd = 5'd4; wb_wen = 1;
        #1;
        chk("R2 sel_a from mem", sel_a, 1);
        chk("R3 sel_b from wb", sel_b, 2);
        ex_rs2 = 5'd3; ex_rs1 = 5'd4;
        #1;
        chk("R2 sel_b from mem", sel_b, 1);
        chk("R3 sel_a from wb", sel_a, 2);
        ex_rs1 = 5'd9; mem_rd = 5'd9; wb_rd = 5'd9;
        #1;
        chk("R4 mem over wb", sel_a, 1);
        set_idle();
    endtask

    task automatic t_zero_and_wen();
        set_idle();
        ex_rs1 = 5'd0; mem_rd = 5'd0; mem_wen = 1; wb_rd = 5'd0; wb_wen = 1;
        #1;
        chk("R5 r0 no fwd", sel_a, 0);
        chk("R5 r0 no bypass", id_byp_a, 0);
        ex_rs2 = 5'd6; mem_rd = 5'd6; mem_wen = 0; wb_rd = 5'd6; wb_wen = 0;
        #1;
        chk("R5 wen low no fwd", sel_b, 0);
        set_idle();
        ex_is_load = 1; ex_wen = 1; ex_rd = 5'd0; id_rs1 = 5'd0; id_use_rs1 = 1;
        #1;
        chk("R5 r0 no stall", stall, 0);
        ex_rd = 5'd8; id_rs1 = 5'd8; ex_wen = 0;
        #1;
        chk("R5 load wen low no stall", stall, 0);
        settle_idle();
    endtask

    task automatic t_load_use();
        next_cycle();
        set_idle();
        ex_is_load = 1; ex_wen = 1; ex_rd = 5'd7;
        id_rs2 = 5'd7; id_use_rs2 = 0;
        #1;
        chk("R6 unused source no stall", stall, 0);
        id_rs1 = 5'd7; id_use_rs1 = 1;
        #1;
        chk("R6 load-use stall", stall, 1);
        next_cycle();
        // bubble cycle: keep a live hazard and a matching memory result
        ex_rs1 = 5'd7; mem_rd = 5'd7; mem_wen = 1;
        #1;
        chk("R10 bubble flag", ex_bubble, 1);
        chk("R10 bubble sel_a", sel_a, 0);
        chk("R12 no second stall", stall, 0);
        set_idle();
        next_cycle();
        #1;
        chk("R10 bubble clears", ex_bubble, 0);
        settle_idle();
    endtask

    task automatic t_store_id();
        set_idle();
        ex_is_load = 1; ex_wen = 1; ex_rd = 5'd11;
        id_is_store = 1; id_use_rs1 = 1; id_use_rs2 = 1;
        id_rs1 = 5'd2; id_rs2 = 5'd11;
        #1;
        chk("R7 store data no stall", stall, 0);
        id_rs1 = 5'd11; id_rs2 = 5'd12;
        #1;
        chk("R7 store base stalls", stall, 1);
        settle_idle();
    endtask

    task automatic t_store_ex();
        set_idle();
        ex_is_store = 1; ex_rs2 = 5'd13;
        mem_is_load = 1; mem_wen = 1; mem_rd = 5'd13;
        wb_wen = 1; wb_rd = 5'd13;
        #1;
        chk("R8 store data skips load, takes wb", sel_b, 2);
        wb_rd = 5'd14;
        #1;
        chk("R8 store data skips load, takes rf", sel_b, 0);
        ex_is_store = 0;
        #1;
        chk("R8 non-store takes mem", sel_b, 1);
        set_idle();
    endtask

    task automatic t_store_mem();
        set_idle();
        mem_is_store = 1; mem_rs2 = 5'd15; wb_wen = 1; wb_rd = 5'd15;
        #1;
        chk("R9 store data from wb", st_from_wb, 1);
        wb_rd = 5'd16;
        #1;
        chk("R9 no match", st_from_wb, 0);
        wb_rd = 5'd15; mem_is_store = 0;
        #1;
        chk("R9 not a store", st_from_wb, 0);
        set_idle();
    endtask

    task automatic t_id_bypass();
        set_idle();
        wb_wen = 1; wb_rd = 5'd6; id_rs1 = 5'd6; id_rs2 = 5'd17;
        #1;
        chk("R11 bypass a", id_byp_a, 1);
        chk("R11 no bypass b", id_byp_b, 0);
        id_rs2 = 5'd6;
        #1;
        chk("R11 bypass b", id_byp_b, 1);
        wb_wen = 0;
        #1;
        chk("R11 wen low", {id_byp_a, id_byp_b}, 0);
        set_idle();
    endtask

    initial begin
        set_idle();
        t_reset();
        t_alu_fwd();
        t_zero_and_wen();
        t_load_use();
        t_store_id();
        t_store_ex();
        t_store_mem();
        t_id_bypass();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule